// File: doc/BRIEF.md
# Multi-Sector Disk Read Sequencer

This block runs the data phase of a disk read once the command bytes have been collected. On a start pulse it takes the requested cylinder, head, sector and size code, together with a final sector number and a head-settle count. If the head is not yet loaded, it loads it and waits out the settle interval. It then watches a byte stream that has already been deserialized from the disk, looking for sector ID fields. When an ID field matches the request, it hands the following data field to the host one byte at a time through a DMA request and acknowledge pair.

After each sector it moves on to the next sector number without any help from the host. It stops when it has finished the last sector of the track, or when the host raises terminal count during an acknowledge. On stopping it gives a one-cycle done pulse and holds the final ID values for the result phase.

Bit-level encoding, data separation and head stepping are handled elsewhere. The stream arrives here as bytes, each tagged with a mark code.

Top module: `msr_read_seq`

## Requirements
- R1: The number of data bytes moved for one sector is 128 shifted left by the size code. Any size code above 3 moves 1024 bytes.
- R2: The first start after reset sets head_load high. No ID field is examined until settle_ms pulses of tick_ms have passed. If head_load is already high, ID scanning begins the cycle after start with no wait.
- R3: A data field is transferred only if the ID field just before it matches the request in cylinder, head, sector and size code, comparing all four raw bytes. Any other ID field, and the data that follows it, produces no DMA request.
- R4: When a sector finishes without terminal count and its number differs from the final sector, the sector number is incremented by one. The search then continues for that next sector.
- R5: When a sector whose number equals req_eot finishes without terminal count, the command ends. res_sec reports that sector.
- R6: Each data byte raises dma_req and places the byte on dma_data. dma_req stays high, with the byte unchanged, until a cycle in which dma_ack_n is low.
- R7: If tc is high in a cycle where a byte is acknowledged, the command ends after that byte. res_sec reports the sector in progress, and the rest of that sector's bytes raise no request.
- R8: done is high for exactly one cycle per command. In that cycle res_cyl, res_head and res_size carry the requested values, and the res outputs hold until the next command ends.
- R9: The stream is qualified by rx_valid and tagged by rx_mark: 01 is an ID mark followed by four plain bytes in the order cylinder, head, sector, size; 10 is a data mark followed by the record bytes; 00 is a plain byte.
- R10: While reset is held, dma_req, done and head_load are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond enable for the settle count |
| start | input | 1 | Start pulse; request fields are latched with it |
| req_cyl | input | 8 | Requested cylinder |
| req_head | input | 8 | Requested head address |
| req_sec | input | 8 | First sector to read |
| req_size | input | 8 | Size code of the record |
| req_eot | input | 8 | Final sector number of the track |
| settle_ms | input | 4 | Head settle time in ticks |
| rx_valid | input | 1 | Stream byte or mark valid |
| rx_mark | input | 2 | Mark code of the stream item |
| rx_byte | input | 8 | Stream byte |
| dma_req | output | 1 | DMA request, active high |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_data | output | 8 | Byte offered to the host |
| tc | input | 1 | Terminal count |
| head_load | output | 1 | Head load command |
| done | output | 1 | End-of-command pulse |
| res_cyl | output | 8 | Result cylinder |
| res_head | output | 8 | Result head |
| res_sec | output | 8 | Result sector |
| res_size | output | 8 | Result size code |

## Verification
One command is issued with the head unloaded and a matching ID sent during the settle wait. That command also carries ID fields that are wrong in only one of sector, cylinder or size code. Together these separate a design that waits out the settle interval and compares all four bytes from one that checks the sector alone. Two runs end on terminal count, one in the middle of a sector and one on a sector's last byte with the track not yet finished. These show whether terminal count overrides the loop and whether the sector number is held back. A size code of 5 checks the clamp to 1024 bytes. A two-sector run to the final sector checks the increment and the stop at end of track.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LEN_W = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SCAN,
    ST_IDRD,
    ST_WDAM,
    ST_DATA
  } seq_st_t;

  typedef enum logic [1:0] {
    MK_BYTE = 2'b00,
    MK_ID   = 2'b01,
    MK_DATA = 2'b10,
    MK_RSVD = 2'b11
  } mark_t;

  typedef struct packed {
    logic [7:0] cyl;
    logic [7:0] head;
    logic [7:0] sec;
    logic [7:0] size;
  } chrn_t;

  function automatic logic [LEN_W-1:0] rec_len(input logic [7:0] n);
    logic [1:0] s;
    s = (n > 8'd3) ? 2'd3 : n[1:0];
    return 11'd128 << s;
  endfunction
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: the settle count only moves on a tick or a load
  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/id_matcher.sv
module id_matcher
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_i,
  input  chrn_t      want,
  output logic       hit,
  output logic       miss
);
  logic        act_q, act_d;
  logic [1:0]  idx_q, idx_d;
  logic [23:0] sh_q, sh_d;
  logic        hit_q, hit_d, miss_q, miss_d;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    hit_d  = 1'b0;
    miss_d = 1'b0;
    if (clr) begin
      act_d = 1'b1;
      idx_d = 2'd0;
    end else if (act_q && byte_vld) begin
      if (idx_q == 2'd3) begin
        act_d = 1'b0;
        if ({sh_q, byte_i} == want) hit_d  = 1'b1;
        else                        miss_d = 1'b1;
      end else begin
        sh_d  = {sh_q[15:0], byte_i};
        idx_d = idx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= 2'd0;
      sh_q   <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign hit  = hit_q;
  assign miss = miss_q;

  // R3: one verdict per ID field, never both
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
  // R9: a verdict follows the fourth ID byte
  a_r9_verdict_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> $past(byte_vld));
endmodule

// File: rtl/data_mover.sv
module data_mover
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             byte_vld,
  input  logic [7:0]       byte_i,
  input  logic             dma_ack_n,
  input  logic             tc,
  output logic             dma_req,
  output logic [7:0]       dma_data,
  output logic             end_p,
  output logic             end_tc
);
  logic             act_q, act_d;
  logic             req_q, req_d;
  logic [7:0]       dat_q, dat_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             end_q, end_d;
  logic             etc_q, etc_d;
  logic             ack;

  assign ack = req_q && !dma_ack_n;

  always_comb begin
    act_d = act_q;
    req_d = req_q;
    dat_d = dat_q;
    cnt_d = cnt_q;
    end_d = 1'b0;
    etc_d = etc_q;
    if (go) begin
      act_d = 1'b1;
      req_d = 1'b0;
      cnt_d = '0;
      etc_d = 1'b0;
    end else if (act_q) begin
      if (ack) begin
        req_d = 1'b0;
        cnt_d = cnt_q + 1'b1;
        if (tc || (cnt_q == len - 1'b1)) begin
          act_d = 1'b0;
          end_d = 1'b1;
          etc_d = tc;
        end
      end
      if (byte_vld && act_d && (!req_q || ack)) begin
        req_d = 1'b1;
        dat_d = byte_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      req_q <= 1'b0;
      dat_q <= '0;
      cnt_q <= '0;
      end_q <= 1'b0;
      etc_q <= 1'b0;
    end else begin
      act_q <= act_d;
      req_q <= req_d;
      dat_q <= dat_d;
      cnt_q <= cnt_d;
      end_q <= end_d;
      etc_q <= etc_d;
    end
  end

  assign dma_req  = req_q;
  assign dma_data = dat_q;
  assign end_p    = end_q;
  assign end_tc   = etc_q;

  // R6: an unanswered request stays up with its byte unchanged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack_n) |=> (dma_req && $stable(dma_data)));
  // R1: the byte count never reaches the record length while active
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < len));
endmodule

// File: rtl/msr_read_seq.sv
module msr_read_seq
  import msr_pkg::*;
#(
  parameter int SETTLE_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_ms,
  input  logic                start,
  input  logic [7:0]          req_cyl,
  input  logic [7:0]          req_head,
  input  logic [7:0]          req_sec,
  input  logic [7:0]          req_size,
  input  logic [7:0]          req_eot,
  input  logic [SETTLE_W-1:0] settle_ms,
  input  logic                rx_valid,
  input  logic [1:0]          rx_mark,
  input  logic [7:0]          rx_byte,
  output logic                dma_req,
  input  logic                dma_ack_n,
  output logic [7:0]          dma_data,
  input  logic                tc,
  output logic                head_load,
  output logic                done,
  output logic [7:0]          res_cyl,
  output logic [7:0]          res_head,
  output logic [7:0]          res_sec,
  output logic [7:0]          res_size
);
  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rs_q[SYNC_STAGES-1];

  seq_st_t st_q, st_d;
  chrn_t   cmd_q, cmd_d;
  chrn_t   res_q, res_d;
  logic [7:0] eot_q, eot_d;
  logic    hl_q, hl_d;
  logic    done_q, done_d;
  logic    tmr_ld, tmr_zero;
  logic    id_clr, id_hit, id_miss;
  logic    mv_go, mv_end, mv_tc;
  logic    is_id, is_dam, is_byte;

  assign is_id   = rx_valid && (rx_mark == MK_ID);
  assign is_dam  = rx_valid && (rx_mark == MK_DATA);
  assign is_byte = rx_valid && (rx_mark == MK_BYTE);

  settle_timer #(.CW(SETTLE_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_ns),
    .load  (tmr_ld),
    .val   (settle_ms),
    .tick  (tick_ms),
    .zero  (tmr_zero)
  );

  id_matcher u_idm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .clr      (id_clr),
    .byte_vld (is_byte && (st_q == ST_IDRD)),
    .byte_i   (rx_byte),
    .want     (cmd_q),
    .hit      (id_hit),
    .miss     (id_miss)
  );

  data_mover u_mv (
    .clk       (clk),
    .rst_n     (rst_ns),
    .go        (mv_go),
    .len       (rec_len(cmd_q.size)),
    .byte_vld  (is_byte && (st_q == ST_DATA)),
    .byte_i    (rx_byte),
    .dma_ack_n (dma_ack_n),
    .tc        (tc),
    .dma_req   (dma_req),
    .dma_data  (dma_data),
    .end_p     (mv_end),
    .end_tc    (mv_tc)
  );

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    eot_d  = eot_q;
    res_d  = res_q;
    hl_d   = hl_q;
    done_d = 1'b0;
    tmr_ld = 1'b0;
    id_clr = 1'b0;
    mv_go  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cmd_d = '{cyl: req_cyl, head: req_head, sec: req_sec, size: req_size};
          eot_d = req_eot;
          if (!hl_q) begin
            hl_d   = 1'b1;
            tmr_ld = 1'b1;
            st_d   = ST_SETTLE;
          end else begin
            st_d = ST_SCAN;
          end
        end
      end
      ST_SETTLE: if (tmr_zero) st_d = ST_SCAN;
      ST_SCAN: begin
        if (is_id) begin
          id_clr = 1'b1;
          st_d   = ST_IDRD;
        end
      end
      ST_IDRD: begin
        if (id_hit)       st_d = ST_WDAM;
        else if (id_miss) st_d = ST_SCAN;
      end
      ST_WDAM: begin
        if (is_id) begin
          id_clr = 1'b1;
          st_d   = ST_IDRD;
        end else if (is_dam) begin
          mv_go = 1'b1;
          st_d  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (mv_end) begin
          if (mv_tc || (cmd_q.sec == eot_q)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            res_d  = cmd_q;
          end else begin
            cmd_d.sec = cmd_q.sec + 8'd1;
            st_d      = ST_SCAN;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      eot_q  <= '0;
      res_q  <= '0;
      hl_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      eot_q  <= eot_d;
      res_q  <= res_d;
      hl_q   <= hl_d;
      done_q <= done_d;
    end
  end

  assign head_load = hl_q;
  assign done      = done_q;
  assign res_cyl   = res_q.cyl;
  assign res_head  = res_q.head;
  assign res_sec   = res_q.sec;
  assign res_size  = res_q.size;

  // R3: no request outside a matched data field
  a_r3_req_in_data: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q != ST_DATA) |-> !dma_req);
  // R2: settle wait only with the head loaded
  a_r2_settle_loaded: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_SETTLE) |-> head_load);
  // R4: returning to the search advances the sector by one
  a_r4_sector_step: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_SCAN && $past(st_q) == ST_DATA) |-> (cmd_q.sec == $past(cmd_q.sec) + 8'd1));
  // R5: a normal end reports the final sector
  a_r5_eot_report: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && !$past(mv_tc)) |-> (res_sec == eot_q));
  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);
endmodule

// File: tb/tb_msr_read_seq.sv
module tb_msr_read_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tick_ms, start, rx_valid, dma_ack_n, tc;
  logic [7:0] req_cyl, req_head, req_sec, req_size, req_eot, rx_byte;
  logic [3:0] settle_ms;
  logic [1:0] rx_mark;
  logic       dma_req, head_load, done;
  logic [7:0] dma_data, res_cyl, res_head, res_sec, res_size;

  msr_read_seq dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start(start),
    .req_cyl(req_cyl), .req_head(req_head), .req_sec(req_sec),
    .req_size(req_size), .req_eot(req_eot), .settle_ms(settle_ms),
    .rx_valid(rx_valid), .rx_mark(rx_mark), .rx_byte(rx_byte),
    .dma_req(dma_req), .dma_ack_n(dma_ack_n), .dma_data(dma_data),
    .tc(tc), .head_load(head_load), .done(done),
    .res_cyl(res_cyl), .res_head(res_head), .res_sec(res_sec), .res_size(res_size)
  );

  int checks = 0;
  int errors = 0;
  int acks   = 0;
  int tc_at  = -1;
  int done_cnt = 0;
  int tcnt = 0;
  logic done_prev = 1'b0;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // millisecond tick every 50 cycles
  always @(negedge clk) begin
    tcnt    = (tcnt == 49) ? 0 : tcnt + 1;
    tick_ms = (tcnt == 0);
  end

  // scoreboard monitor: acknowledges requests and compares bytes (R6)
  always @(negedge clk) begin
    if (!dma_ack_n) begin
      dma_ack_n = 1'b1;
      tc        = 1'b0;
    end else if (dma_req) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R3/R7: unexpected request data %0d expected none", dma_data);
      end else begin
        logic [7:0] e;
        e = q.pop_front();
        if (dma_data !== e) begin
          errors++;
          $display("FAIL R6: dma_data %0d expected %0d", dma_data, e);
        end
      end
      tc = (acks == tc_at);
      acks++;
      dma_ack_n = 1'b0;
    end
  end

  // done pulse monitor (R8)
  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      if (done_prev) begin
        checks++; errors++;
        $display("FAIL R8: done width >1 got %0d expected %0d", 2, 1);
      end
    end
    done_prev = done;
  end

  // R9: one stream item, marks 01 ID, 10 data, 00 plain byte
  task automatic put(input logic [1:0] mk, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_mark = mk; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_mark = 2'b00;
    repeat (2) @(negedge clk);
  endtask

  // driver: ID field, data field, pushes the first nexp bytes as expected
  task automatic send_sector(input logic [7:0] c, input logic [7:0] h, input logic [7:0] r,
                             input logic [7:0] n, input int len, input int nexp);
    put(2'b01, 8'h00);
    put(2'b00, c); put(2'b00, h); put(2'b00, r); put(2'b00, n);
    put(2'b10, 8'h00);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(r * 37 + c * 11 + i * 5 + (i >> 3));
      if (i < nexp) q.push_back(b);
      put(2'b00, b);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [7:0] h, input logic [7:0] r,
                       input logic [7:0] n, input logic [7:0] eot, input logic [3:0] st,
                       input int tcat);
    @(negedge clk);
    acks = 0; tc_at = tcat; done_cnt = 0;
    req_cyl = c; req_head = h; req_sec = r; req_size = n; req_eot = eot; settle_ms = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_cmd(input string tag, input int exp_acks, input logic [7:0] c,
                            input logic [7:0] h, input logic [7:0] r, input logic [7:0] n);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R8 done count", done_cnt, 1);
    chk(q.size() == 0, {tag, " bytes left in queue"}, q.size(), 0);
    chk(acks == exp_acks, {tag, " byte count"}, acks, exp_acks);
    chk(res_sec == r, {tag, " res_sec"}, res_sec, r);
    chk(res_cyl == c && res_head == h, "R8 res_cyl/res_head", {res_cyl, res_head}, {c, h});
    chk(res_size == n, "R8 res_size", res_size, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles %0d expected < %0d", 150000, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rx_valid = 1'b0; rx_mark = 2'b00; rx_byte = 8'h00;
    dma_ack_n = 1'b1; tc = 1'b0; tick_ms = 1'b0;
    req_cyl = 0; req_head = 0; req_sec = 0; req_size = 0; req_eot = 0; settle_ms = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!dma_req, "R10 dma_req", dma_req, 0);
    chk(!done, "R10 done", done, 0);
    chk(!head_load, "R10 head_load", head_load, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // A: head unloaded, settle 4 ticks, two sectors to end of track
    issue(8'd2, 8'd0, 8'd1, 8'd0, 8'd2, 4'd4, -1);
    chk(head_load, "R2 head_load after start", head_load, 1);
    send_sector(8'd2, 8'd0, 8'd1, 8'd0, 128, 0);   // R2: ID arrives during settle
    send_sector(8'd2, 8'd0, 8'd5, 8'd0, 128, 0);   // R3: wrong sector
    send_sector(8'd3, 8'd0, 8'd1, 8'd0, 128, 0);   // R3: wrong cylinder
    send_sector(8'd2, 8'd0, 8'd1, 8'd1, 128, 0);   // R3: wrong size code
    send_sector(8'd2, 8'd0, 8'd1, 8'd0, 128, 128);
    send_sector(8'd2, 8'd0, 8'd2, 8'd0, 128, 128); // R4 next sector, R5 end
    finish_cmd("R5", 256, 8'd2, 8'd0, 8'd2, 8'd0);

    // B: head loaded (no settle), tc in the middle of the second sector
    issue(8'd7, 8'd1, 8'd3, 8'd1, 8'd9, 4'd15, 299);
    send_sector(8'd7, 8'd1, 8'd3, 8'd1, 256, 256);
    send_sector(8'd7, 8'd1, 8'd4, 8'd1, 256, 44);
    send_sector(8'd7, 8'd1, 8'd5, 8'd1, 256, 0);
    finish_cmd("R7", 300, 8'd7, 8'd1, 8'd4, 8'd1);

    // C: size code above 3 moves 1024 bytes
    issue(8'd1, 8'd0, 8'd8, 8'd5, 8'd8, 4'd0, -1);
    send_sector(8'd1, 8'd0, 8'd8, 8'd5, 1024, 1024);
    finish_cmd("R1", 1024, 8'd1, 8'd0, 8'd8, 8'd5);

    // D: tc on the last byte of a sector before end of track
    issue(8'd4, 8'd0, 8'd1, 8'd0, 8'd3, 4'd0, 127);
    send_sector(8'd4, 8'd0, 8'd1, 8'd0, 128, 128);
    send_sector(8'd4, 8'd0, 8'd2, 8'd0, 128, 0);
    finish_cmd("R7", 128, 8'd4, 8'd0, 8'd1, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule